// File: doc/BRIEF.md
# Hysteretic Automatic RTS Controller

This block drives the active-low request-to-send pin of a UART from the fill level of its receive FIFO. Software selects one of four trigger levels. The block raises a receive-threshold interrupt request whenever the FIFO count is at or above that level. When automatic control is switched on, RTS# is released (driven high) once the count reaches the next trigger level above the selected one. It is driven low again once the count falls below the next trigger level beneath the selected one. Between those two points the pin keeps its last value. The gap between the release point and the re-assert point stops the pin from toggling on every byte.

Automatic control needs two things: its enable bit, and software having first requested RTS through its register bit. In every other case the pin is a general-purpose output that mirrors the inverse of the software bit. Both outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `auto_rts_ctrl`

## Requirements
- R1: With `auto_rts_en_i` = 0, `rts_n_o` equals the inverse of `sw_rts_i` from the previous cycle, whatever the FIFO count is.
- R2: `rx_irq_o` is 1 in the cycle after `fifo_cnt_i` is at or above the selected trigger level, and 0 in the cycle after it is below that level.
- R3: While automatic control is active (`auto_rts_en_i` = 1 and `sw_rts_i` = 1), a count at or above the upper threshold drives `rts_n_o` to 1 on the next cycle.
- R4: While automatic control is active, a count below the lower threshold drives `rts_n_o` to 0 on the next cycle.
- R5: While automatic control is active and the count lies between the two thresholds (at or above the lower one, below the upper one), `rts_n_o` keeps its previous value.
- R6: With `sw_rts_i` = 0, `rts_n_o` is 1 on the next cycle even when `auto_rts_en_i` = 1, and the hysteresis state is cleared. When automatic control resumes with the count between the thresholds, `rts_n_o` goes to 0.
- R7: The selected trigger level is set by `trig_sel_i`: 0 gives 8, 1 gives 32, 2 gives 64 and 3 gives 120. The upper threshold is the next table entry, or 128 (FIFO full) for selection 3. The lower threshold is the previous table entry. For selection 0 there is no previous entry, so RTS# is re-asserted only when the count is 0.
- R8: After reset, `rts_n_o` is 1, `rx_irq_o` is 0 and the hysteresis state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_cnt_i | input | 8 | Number of entries in the receive FIFO (0 to 128) |
| trig_sel_i | input | 2 | Trigger level selection |
| auto_rts_en_i | input | 1 | Enables automatic RTS control |
| sw_rts_i | input | 1 | Software RTS bit; 1 requests RTS# low |
| rts_n_o | output | 1 | RTS# pin, active low |
| rx_irq_o | output | 1 | Receive-threshold interrupt request |

## Verification
The assertions check on every cycle that the general-purpose fallback holds, that the software bit gates the pin, and that the interrupt follows the trigger comparison. They also check that RTS# releases above the upper threshold, re-asserts below the lower one, and that the hysteresis state stays put while the count is inside the band. Only the bench scenarios can show that the right table entries are chosen for each selection, including the full-FIFO top and the empty-FIFO floor. The same holds for the path through the band in both directions and for the clearing of the state when software withdraws RTS and then requests it again.

// File: rtl/auto_rts_pkg.sv
package auto_rts_pkg;
  localparam int unsigned NUM_TRIG = 4;
  typedef logic [$clog2(NUM_TRIG)-1:0] trig_sel_t;
endpackage

// File: rtl/rts_trig_lut.sv
module rts_trig_lut
  import auto_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL0  = 8,
  parameter int unsigned LVL1  = 32,
  parameter int unsigned LVL2  = 64,
  parameter int unsigned LVL3  = 120,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  trig_sel_t        sel_i,
  output logic [CNT_W-1:0] level_o,
  output logic [CNT_W-1:0] upper_o,
  output logic [CNT_W-1:0] lower_o
);
  localparam int unsigned LVLS [NUM_TRIG] = '{LVL0, LVL1, LVL2, LVL3};

  logic [CNT_W-1:0] lvl_tab [NUM_TRIG];
  logic [CNT_W-1:0] up_tab  [NUM_TRIG];
  logic [CNT_W-1:0] lo_tab  [NUM_TRIG];

  // neighbour table: top entry tops out at FIFO full, bottom entry floors at empty
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_tab
    assign lvl_tab[g] = CNT_W'(LVLS[g]);
    if (g == NUM_TRIG - 1) begin : g_top
      assign up_tab[g] = CNT_W'(DEPTH);
    end else begin : g_up
      assign up_tab[g] = CNT_W'(LVLS[g+1]);
    end
    if (g == 0) begin : g_bot
      assign lo_tab[g] = CNT_W'(1);
    end else begin : g_lo
      assign lo_tab[g] = CNT_W'(LVLS[g-1]);
    end
  end

  assign level_o = lvl_tab[sel_i];
  assign upper_o = up_tab[sel_i];
  assign lower_o = lo_tab[sel_i];
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             sw_rts_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic [CNT_W-1:0] lower_i,
  output logic             rts_n_o
);
  logic halt_q, halt_d, rts_n_q, rts_n_d;
  logic over_up, under_lo, in_band;

  assign over_up  = cnt_i >= upper_i;
  assign under_lo = cnt_i < lower_i;
  assign in_band  = !over_up && !under_lo;

  always_comb begin
    halt_d = halt_q;
    if (!auto_i)       halt_d = 1'b0;
    else if (over_up)  halt_d = 1'b1;
    else if (under_lo) halt_d = 1'b0;
  end

  assign rts_n_d = auto_i ? halt_d : !sw_rts_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      halt_q  <= halt_d;
      rts_n_q <= rts_n_d;
    end
  end

  assign rts_n_o = rts_n_q;

  AST_RELEASE_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && over_up) |=> rts_n_o); // R3
  AST_REASSERT_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && under_lo) |=> !rts_n_o); // R4
  AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && in_band) |=> (halt_q == $past(halt_q))); // R5
  AST_STATE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> !halt_q); // R6
endmodule

// File: rtl/auto_rts_ctrl.sv
module auto_rts_ctrl
  import auto_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL0  = 8,
  parameter int unsigned LVL1  = 32,
  parameter int unsigned LVL2  = 64,
  parameter int unsigned LVL3  = 120,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             auto_rts_en_i,
  input  logic             sw_rts_i,
  output logic             rts_n_o,
  output logic             rx_irq_o
);
  logic [CNT_W-1:0] level, upper, lower;
  logic             irq_q;
  logic             auto_act;

  rts_trig_lut #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_lut (
    .sel_i   (trig_sel_t'(trig_sel_i)),
    .level_o (level),
    .upper_o (upper),
    .lower_o (lower)
  );

  // auto control only once software has requested RTS
  assign auto_act = auto_rts_en_i && sw_rts_i;

  rts_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_i   (auto_act),
    .sw_rts_i (sw_rts_i),
    .cnt_i    (fifo_cnt_i),
    .upper_i  (upper),
    .lower_i  (lower),
    .rts_n_o  (rts_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fifo_cnt_i >= level;
  end

  assign rx_irq_o = irq_q;

  AST_GPO_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> (rts_n_o == !$past(sw_rts_i))); // R1
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i >= level) |=> rx_irq_o); // R2
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i < level) |=> !rx_irq_o); // R2
  AST_SW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_rts_i |=> rts_n_o); // R6
endmodule

// File: tb/auto_rts_ctrl_bench.sv
`timescale 1ns/1ps
module auto_rts_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt = '0;
  logic [1:0] sel = '0;
  logic       en = 1'b0;
  logic       sw = 1'b0;
  logic       rts_n, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit    q_rts [$];
  bit    q_irq [$];
  string q_tag [$];
  bit    m_halt = 1'b0;

  always #2.5 clk = ~clk;

  auto_rts_ctrl u_auto_rts_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .fifo_cnt_i    (cnt),
    .trig_sel_i    (sel),
    .auto_rts_en_i (en),
    .sw_rts_i      (sw),
    .rts_n_o       (rts_n),
    .rx_irq_o      (irq)
  );

  function automatic int lvl_of(int s);
    case (s)
      0: return 8;
      1: return 32;
      2: return 64;
      default: return 120;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs, push model expectation
  task automatic step(int c, int s, bit e, bit w, string tag);
    int up, lo;
    bit act;
    @(negedge clk);
    cnt = 8'(c); sel = 2'(s); en = e; sw = w;
    up  = (s == 3) ? 128 : lvl_of(s + 1);
    lo  = (s == 0) ? 1 : lvl_of(s - 1);
    act = e && w;
    if (!act)        m_halt = 1'b0;
    else if (c >= up) m_halt = 1'b1;
    else if (c < lo)  m_halt = 1'b0;
    q_rts.push_back(act ? m_halt : !w);
    q_irq.push_back(c >= lvl_of(s));
    q_tag.push_back(tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string t;
        bit er, ei;
        t  = q_tag.pop_front();
        er = q_rts.pop_front();
        ei = q_irq.pop_front();
        check(t, rts_n, er, "rts_n_o");
        check(t, irq, ei, "rx_irq_o");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", rts_n, 1'b1, "rts_n_o in reset");
    check("R8", irq, 1'b0, "rx_irq_o in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8", rts_n, 1'b1, "rts_n_o after reset");
    // R1 general-purpose output
    step(100, 1, 0, 1, "R1");
    step(100, 1, 0, 0, "R1");
    step(0,   1, 0, 1, "R1");
    // R2 interrupt around level 32
    step(31, 1, 0, 1, "R2");
    step(32, 1, 0, 1, "R2");
    step(40, 1, 0, 1, "R2");
    step(31, 1, 0, 1, "R2");
    // R3/R4/R5 hysteresis, sel 1: release at 64, re-assert below 8
    step(10, 1, 1, 1, "R5");
    step(63, 1, 1, 1, "R5");
    step(64, 1, 1, 1, "R3");
    step(40, 1, 1, 1, "R5");
    step(8,  1, 1, 1, "R5");
    step(7,  1, 1, 1, "R4");
    step(40, 1, 1, 1, "R5");
    // R6 software gating clears state
    step(70, 1, 1, 1, "R3");
    step(70, 1, 1, 0, "R6");
    step(40, 1, 1, 0, "R6");
    step(40, 1, 1, 1, "R6");
    // R7 lowest selection: release at 32, re-assert at empty
    step(32, 0, 1, 1, "R7");
    step(1,  0, 1, 1, "R7");
    step(0,  0, 1, 1, "R7");
    // R7 highest selection: release at full, re-assert below 64
    step(127, 3, 1, 1, "R7");
    step(128, 3, 1, 1, "R7");
    step(64,  3, 1, 1, "R7");
    step(63,  3, 1, 1, "R7");
    step(119, 3, 0, 1, "R7");
    step(120, 3, 0, 1, "R7");
    // R7 sel 2: release at 120, re-assert below 32
    step(119, 2, 1, 1, "R7");
    step(120, 2, 1, 1, "R7");
    step(32,  2, 1, 1, "R7");
    step(31,  2, 1, 1, "R7");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule